// File: doc/BRIEF.md
# Raster timing generator

This block produces the horizontal and vertical timing of a raster display from three software-written words and a control word. Each axis runs through four phases in a fixed order: sync, a delay before the visible gate, the visible gate itself, and a remainder that fills the line or frame up to its programmed total. The horizontal axis advances one step per clock (one pixel). The vertical axis advances one step per completed line.

The outputs are hsync, vsync, a composite sync, a blank signal and a visible-area strobe for the pixel pipeline. There is a one-cycle pulse at each line start and a one-cycle pulse at each frame start for interrupt logic. The block also outputs the horizontal and vertical position counters. Each of the four sync and blank outputs has its own polarity bit. A video-enable bit in the control word holds the whole generator in its idle state while it is clear.

All outputs and both counters come from the same register stage, so they stay aligned with each other.

Top module: `raster_tgen`

## Requirements
- R1: Every programmed count is one less than the real duration. The horizontal timing word holds the sync width in bits [31:24], the gate delay in [23:16] and the visible gate in [15:0], and the vertical timing word uses the same layout. The length word holds the horizontal total in [31:16] and the vertical total in [15:0]. Hsync stays active for sync+1 cycles, and hsync onsets repeat every htotal+1 cycles.
- R2: Within a line the phases run in this order: sync, gate delay, visible gate, remainder. The first visible pixel of a line comes sync+gdelay+2 cycles after the hsync onset, and the visible run lasts gate+1 cycles.
- R3: The vertical axis counts lines. Vsync lasts vsync+1 lines, and a frame lasts vtotal+1 lines. The first visible line starts vsync+vgdelay+2 lines after the vsync onset. A vertical phase changes only at a line start, so every vsync onset coincides with an hsync onset.
- R4: The visible strobe is high only when both axes are in their visible gate, which gives (hgate+1)*(vgate+1) strobe cycles per frame. The active-high blank is the complement of the strobe.
- R5: The active-high composite sync equals the XOR of the active-high hsync and vsync in every cycle.
- R6: Control bits 12, 13, 14 and 15 invert hsync, vsync, composite sync and blank respectively. An inverted output is low when active.
- R7: A zero sync width or zero gate delay still gives a phase of exactly one cycle, or one line on the vertical axis.
- R8: Control bit 0 is video enable. Two cycles after it is cleared, the syncs are at their inactive level, blank is active, the strobe and the pulses are low and both counters read 0, and they stay so. Two cycles after it is set again, output shows line 0, pixel 0 with hsync, vsync and the frame pulse all active.
- R9: The line-start pulse is high for exactly the first cycle of each hsync. The frame-start pulse is high once per frame, at the vsync onset.
- R10: The position outputs are aligned with the sync outputs: both read 0 at a vsync onset, hcount reaches htotal at the last cycle of a line, and vcount steps by one at the next line start.
- R11: After reset with the control word at zero, hsync, vsync and composite sync are low, blank is high, and the strobe, the pulses and the counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 16 | Control: bit 0 enable, bits 12..15 polarity of hsync, vsync, csync, blank |
| htim_i | input | 32 | Horizontal sync, gate delay, gate (minus-one counts) |
| vtim_i | input | 32 | Vertical sync, gate delay, gate (minus-one counts) |
| len_i | input | 32 | Horizontal total [31:16], vertical total [15:0] |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| csync_o | output | 1 | Composite sync after polarity |
| blank_o | output | 1 | Blank after polarity |
| visible_o | output | 1 | Active-high visible-area strobe |
| line_start_o | output | 1 | One-cycle pulse at each line start |
| frame_start_o | output | 1 | One-cycle pulse at each frame start |
| hcount_o | output | 16 | Horizontal position in the line |
| vcount_o | output | 16 | Vertical line number in the frame |

## Verification
The first timing set uses non-zero sync and delay fields with all polarity bits clear. It shows whether phase widths, the phase order and the vertical-per-line stepping each follow their own field, because every field has a different value. The second set uses zero sync and delay fields with every polarity bit set. It separates a correct one-cycle phase from a skipped phase, and an inverted output from an uninverted one. A disable in mid-frame followed by a re-enable shows whether the generator really returns to line 0, pixel 0, and is not just paused.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int SYNC_W   = 8;
  localparam int GDEL_W   = 8;
  localparam int GATE_W   = 16;
  localparam int LEN_W    = 16;
  localparam int WORD_W   = 32;
  localparam int CTRL_W   = 16;

  localparam int SYNC_LSB = 24;
  localparam int GDEL_LSB = 16;
  localparam int GATE_LSB = 0;
  localparam int HLEN_LSB = 16;
  localparam int VLEN_LSB = 0;

  localparam int CB_EN    = 0;
  localparam int CB_POL_H = 12;
  localparam int CB_POL_V = 13;
  localparam int CB_POL_C = 14;
  localparam int CB_POL_B = 15;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_GDEL  = 2'd1,
    PH_GATE  = 2'd2,
    PH_PORCH = 2'd3
  } phase_t;
endpackage

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int SW = 8,
  parameter int DW = 8,
  parameter int GW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [SW-1:0] sync_len,
  input  logic [DW-1:0] gdel_len,
  input  logic [GW-1:0] gate_len,
  input  logic [CW-1:0] total_len,
  output logic [CW-1:0] pos_o,
  output phase_t        phase_o,
  output logic          wrap_o
);
  localparam int SD_W = (SW > DW) ? SW : DW;
  localparam int PC_W = (GW > SD_W) ? GW : SD_W;

  logic [CW-1:0]   pos_q, pos_d;
  logic [PC_W-1:0] pc_q, pc_d;
  phase_t          ph_q, ph_d;
  logic [PC_W-1:0] cur_lim;
  logic            at_end;

  always_comb begin
    case (ph_q)
      PH_SYNC: cur_lim = PC_W'(sync_len);
      PH_GDEL: cur_lim = PC_W'(gdel_len);
      PH_GATE: cur_lim = PC_W'(gate_len);
      default: cur_lim = '0;
    endcase
  end

  assign at_end = (pos_q == total_len);

  always_comb begin
    pos_d = pos_q;
    ph_d  = ph_q;
    pc_d  = pc_q;
    if (clr) begin
      pos_d = '0;
      ph_d  = PH_SYNC;
      pc_d  = '0;
    end else if (step) begin
      if (at_end) begin
        pos_d = '0;
        ph_d  = PH_SYNC;
        pc_d  = '0;
      end else begin
        pos_d = pos_q + 1'b1;
        if (ph_q != PH_PORCH) begin
          if (pc_q == cur_lim) begin
            pc_d = '0;
            case (ph_q)
              PH_SYNC: ph_d = PH_GDEL;
              PH_GDEL: ph_d = PH_GATE;
              default: ph_d = PH_PORCH;
            endcase
          end else begin
            pc_d = pc_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      ph_q  <= PH_SYNC;
      pc_q  <= '0;
    end else begin
      pos_q <= pos_d;
      ph_q  <= ph_d;
      pc_q  <= pc_d;
    end
  end

  assign pos_o   = pos_q;
  assign phase_o = ph_q;
  assign wrap_o  = step && !clr && at_end;

  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && at_end) |=> (pos_q == '0 && ph_q == PH_SYNC)); // R1

  AST_SYNC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !at_end && ph_q == PH_SYNC) |=> (ph_q == PH_SYNC || ph_q == PH_GDEL)); // R2

  AST_GDEL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !at_end && ph_q == PH_GDEL) |=> (ph_q == PH_GDEL || ph_q == PH_GATE)); // R2

  AST_GATE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !at_end && ph_q == PH_GATE) |=> (ph_q == PH_GATE || ph_q == PH_PORCH)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> ($stable(pos_q) && $stable(ph_q))); // R3

  AST_CLEAR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pos_q == '0 && ph_q == PH_SYNC && pc_q == '0)); // R8
endmodule

// File: rtl/rtg_outreg.sv
module rtg_outreg
  import rtg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  phase_t        h_ph,
  input  phase_t        v_ph,
  input  logic [CW-1:0] h_pos,
  input  logic [CW-1:0] v_pos,
  input  logic          pol_h,
  input  logic          pol_v,
  input  logic          pol_c,
  input  logic          pol_b,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          csync_o,
  output logic          blank_o,
  output logic          visible_o,
  output logic          line_start_o,
  output logic          frame_start_o,
  output logic [CW-1:0] hcount_o,
  output logic [CW-1:0] vcount_o
);
  logic          hs_a, vs_a, cs_a, vis_a, ls_a, fs_a;
  logic          hs_d, vs_d, cs_d, bl_d;
  logic [CW-1:0] hc_d, vc_d;

  always_comb begin
    hs_a  = run && (h_ph == PH_SYNC);
    vs_a  = run && (v_ph == PH_SYNC);
    cs_a  = hs_a ^ vs_a;
    vis_a = run && (h_ph == PH_GATE) && (v_ph == PH_GATE);
    ls_a  = run && (h_pos == '0);
    fs_a  = ls_a && (v_pos == '0);
    hs_d  = hs_a ^ pol_h;
    vs_d  = vs_a ^ pol_v;
    cs_d  = cs_a ^ pol_c;
    bl_d  = (!vis_a) ^ pol_b;
    hc_d  = run ? h_pos : '0;
    vc_d  = run ? v_pos : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o       <= 1'b0;
      vsync_o       <= 1'b0;
      csync_o       <= 1'b0;
      blank_o       <= 1'b1;
      visible_o     <= 1'b0;
      line_start_o  <= 1'b0;
      frame_start_o <= 1'b0;
      hcount_o      <= '0;
      vcount_o      <= '0;
    end else begin
      hsync_o       <= hs_d;
      vsync_o       <= vs_d;
      csync_o       <= cs_d;
      blank_o       <= bl_d;
      visible_o     <= vis_a;
      line_start_o  <= ls_a;
      frame_start_o <= fs_a;
      hcount_o      <= hc_d;
      vcount_o      <= vc_d;
    end
  end

  AST_FRAME_IS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> line_start_o); // R9

  AST_LINE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |-> (hcount_o == '0)); // R10
endmodule

// File: rtl/raster_tgen.sv
module raster_tgen
  import rtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [WORD_W-1:0] htim_i,
  input  logic [WORD_W-1:0] vtim_i,
  input  logic [WORD_W-1:0] len_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              csync_o,
  output logic              blank_o,
  output logic              visible_o,
  output logic              line_start_o,
  output logic              frame_start_o,
  output logic [LEN_W-1:0]  hcount_o,
  output logic [LEN_W-1:0]  vcount_o
);
  logic             en_q, en_d;
  logic [LEN_W-1:0] h_pos, v_pos;
  phase_t           h_ph, v_ph;
  logic             h_wrap, v_wrap;

  assign en_d = ctrl_i[CB_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  rtg_axis #(.SW(SYNC_W), .DW(GDEL_W), .GW(GATE_W), .CW(LEN_W)) u_hax (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!en_q),
    .step      (en_q),
    .sync_len  (htim_i[SYNC_LSB +: SYNC_W]),
    .gdel_len  (htim_i[GDEL_LSB +: GDEL_W]),
    .gate_len  (htim_i[GATE_LSB +: GATE_W]),
    .total_len (len_i[HLEN_LSB +: LEN_W]),
    .pos_o     (h_pos),
    .phase_o   (h_ph),
    .wrap_o    (h_wrap)
  );

  rtg_axis #(.SW(SYNC_W), .DW(GDEL_W), .GW(GATE_W), .CW(LEN_W)) u_vax (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!en_q),
    .step      (h_wrap),
    .sync_len  (vtim_i[SYNC_LSB +: SYNC_W]),
    .gdel_len  (vtim_i[GDEL_LSB +: GDEL_W]),
    .gate_len  (vtim_i[GATE_LSB +: GATE_W]),
    .total_len (len_i[VLEN_LSB +: LEN_W]),
    .pos_o     (v_pos),
    .phase_o   (v_ph),
    .wrap_o    (v_wrap)
  );

  rtg_outreg #(.CW(LEN_W)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (en_q),
    .h_ph          (h_ph),
    .v_ph          (v_ph),
    .h_pos         (h_pos),
    .v_pos         (v_pos),
    .pol_h         (ctrl_i[CB_POL_H]),
    .pol_v         (ctrl_i[CB_POL_V]),
    .pol_c         (ctrl_i[CB_POL_C]),
    .pol_b         (ctrl_i[CB_POL_B]),
    .hsync_o       (hsync_o),
    .vsync_o       (vsync_o),
    .csync_o       (csync_o),
    .blank_o       (blank_o),
    .visible_o     (visible_o),
    .line_start_o  (line_start_o),
    .frame_start_o (frame_start_o),
    .hcount_o      (hcount_o),
    .vcount_o      (vcount_o)
  );

  AST_VERT_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !h_wrap) |=> ($stable(v_ph) && $stable(v_pos))); // R3

  AST_VWRAP_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    v_wrap |-> h_wrap); // R3

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!line_start_o && !visible_o && !frame_start_o)); // R8
endmodule

// File: tb/raster_tgen_tb.sv
`timescale 1ns/1ps
module raster_tgen_tb;
  localparam time CLK_P = 20ns;
  localparam int  CAP   = 512;
  localparam int  S_HS = 0, S_VS = 1, S_VIS = 2, S_LS = 3, S_FS = 4, S_CS = 5;

  logic        clk, rst_n;
  logic [15:0] ctrl;
  logic [31:0] htim, vtim, lenw;
  logic        hs, vs, cs, bl, vis, ls, fs;
  logic [15:0] hc, vc;

  int n_chk = 0;
  int n_bad = 0;
  bit p_h, p_v, p_c, p_b;

  logic c_hs [0:CAP-1];
  logic c_vs [0:CAP-1];
  logic c_cs [0:CAP-1];
  logic c_bl [0:CAP-1];
  logic c_vi [0:CAP-1];
  logic c_ls [0:CAP-1];
  logic c_fs [0:CAP-1];
  int   c_hc [0:CAP-1];
  int   c_vc [0:CAP-1];

  raster_tgen u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .htim_i(htim), .vtim_i(vtim), .len_i(lenw),
    .hsync_o(hs), .vsync_o(vs), .csync_o(cs), .blank_o(bl), .visible_o(vis),
    .line_start_o(ls), .frame_start_o(fs), .hcount_o(hc), .vcount_o(vc)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit a_at(int sel, int i);
    case (sel)
      S_HS:    return c_hs[i] ^ p_h;
      S_VS:    return c_vs[i] ^ p_v;
      S_VIS:   return c_vi[i];
      S_LS:    return c_ls[i];
      S_FS:    return c_fs[i];
      default: return c_cs[i] ^ p_c;
    endcase
  endfunction

  function automatic int find_rise(int sel, int from);
    for (int i = (from < 1 ? 1 : from); i < CAP; i++)
      if (a_at(sel, i) && !a_at(sel, i-1)) return i;
    return -1;
  endfunction

  function automatic int run_len(int sel, int st);
    int n = 0;
    for (int i = st; i < CAP; i++) begin
      if (!a_at(sel, i)) break;
      n++;
    end
    return n;
  endfunction

  function automatic int count_in(int sel, int st, int n);
    int k = 0;
    for (int i = st; i < st + n && i < CAP; i++) if (a_at(sel, i)) k++;
    return k;
  endfunction

  task automatic capture(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_hs[i] = hs; c_vs[i] = vs; c_cs[i] = cs; c_bl[i] = bl; c_vi[i] = vis;
      c_ls[i] = ls; c_fs[i] = fs; c_hc[i] = int'(hc); c_vc[i] = int'(vc);
    end
  endtask

  task automatic t_reset;
    ctrl = 16'h0000; htim = '0; vtim = '0; lenw = '0;
    p_h = 0; p_v = 0; p_c = 0; p_b = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", "hsync", int'(hs), 0);
    chk("R11", "vsync", int'(vs), 0);
    chk("R11", "csync", int'(cs), 0);
    chk("R11", "blank", int'(bl), 1);
    chk("R11", "visible+pulses", int'(vis) + int'(ls) + int'(fs), 0);
    chk("R11", "counters", int'(hc) + int'(vc), 0);
  endtask

  // non-zero fields, no inversion: line 20 cycles, frame 9 lines
  task automatic t_frame_a;
    int r, m;
    htim = {8'd2, 8'd1, 16'd7};
    vtim = {8'd1, 8'd0, 16'd3};
    lenw = {16'd19, 16'd8};
    @(negedge clk);
    ctrl = 16'h0001;
    capture(400);
    r = find_rise(S_VS, 1);
    chk("R8", "first vsync onset index", r, 1);
    if (r < 1) r = 1;
    chk("R1", "hsync width", run_len(S_HS, r), 3);
    chk("R1", "hsync period", find_rise(S_HS, r + 1) - r, 20);
    chk("R3", "vsync onset on hsync onset", int'(a_at(S_HS, r) && !a_at(S_HS, r - 1)), 1);
    chk("R3", "vsync width", run_len(S_VS, r), 40);
    chk("R3", "frame period", find_rise(S_VS, r + 1) - r, 180);
    chk("R2", "first visible offset", find_rise(S_VIS, r) - r, 65);
    chk("R2", "visible run", run_len(S_VIS, find_rise(S_VIS, r)), 8);
    chk("R4", "visible per frame", count_in(S_VIS, r, 180), 32);
    m = 0;
    for (int i = 1; i < 400; i++) if (c_bl[i] == c_vi[i]) m++;
    chk("R4", "blank vs strobe mismatches", m, 0);
    m = 0;
    for (int i = 0; i < 400; i++) if (a_at(S_CS, i) != (a_at(S_HS, i) ^ a_at(S_VS, i))) m++;
    chk("R5", "csync mismatches", m, 0);
    chk("R9", "line pulses per frame", count_in(S_LS, r, 180), 9);
    m = 0;
    for (int i = r; i < r + 180; i++) if (a_at(S_LS, i) != (a_at(S_HS, i) && !a_at(S_HS, i-1))) m++;
    chk("R9", "line pulse vs hsync onset", m, 0);
    chk("R9", "frame pulses per frame", count_in(S_FS, r, 180), 1);
    chk("R9", "frame pulse at vsync onset", int'(c_fs[r]), 1);
    chk("R10", "hcount at vsync onset", c_hc[r], 0);
    chk("R10", "vcount at vsync onset", c_vc[r], 0);
    chk("R10", "hcount end of line", c_hc[r + 19], 19);
    chk("R10", "vcount next line", c_vc[r + 20], 1);
  endtask

  // zero sync/delay fields, all outputs inverted: line 10 cycles, frame 5 lines
  task automatic t_frame_b;
    int r;
    @(negedge clk);
    ctrl = 16'h0000;
    repeat (3) @(negedge clk);
    htim = {8'd0, 8'd0, 16'd4};
    vtim = {8'd0, 8'd0, 16'd1};
    lenw = {16'd9, 16'd4};
    p_h = 1; p_v = 1; p_c = 1; p_b = 1;
    ctrl = 16'hF001;
    capture(200);
    r = find_rise(S_VS, 1);
    chk("R8", "first vsync onset index B", r, 1);
    if (r < 1) r = 1;
    chk("R7", "zero sync width", run_len(S_HS, r), 1);
    chk("R7", "zero delay visible offset", find_rise(S_VIS, r + 20) - (r + 20), 2);
    chk("R7", "zero vsync one line", run_len(S_VS, r), 10);
    chk("R7", "zero vdelay first visible line", find_rise(S_VIS, r) - r, 22);
    chk("R4", "visible per frame B", count_in(S_VIS, r, 50), 10);
    chk("R6", "hsync low when active", int'(c_hs[r]), 0);
    chk("R6", "vsync low when active", int'(c_vs[r]), 0);
    chk("R6", "hsync high when idle", int'(c_hs[r + 5]), 1);
    chk("R6", "csync inverted in vsync line", int'(c_cs[r + 5]), 0);
    chk("R6", "blank low when blanking", int'(c_bl[r + 5]), 0);
    chk("R6", "blank high in visible", int'(c_bl[r + 22]), 1);
  endtask

  task automatic t_disable;
    @(negedge clk);
    ctrl = 16'hF000;
    repeat (2) @(negedge clk);
    chk("R8", "off hsync level", int'(hs), 1);
    chk("R8", "off vsync level", int'(vs), 1);
    chk("R8", "off csync level", int'(cs), 1);
    chk("R8", "off blank level", int'(bl), 0);
    chk("R8", "off strobe+pulses", int'(vis) + int'(ls) + int'(fs), 0);
    repeat (15) @(negedge clk);
    chk("R8", "off counters held", int'(hc) + int'(vc), 0);
    chk("R8", "off hsync still idle", int'(hs), 1);
    ctrl = 16'hF001;
    repeat (2) @(negedge clk);
    chk("R8", "restart hsync active", int'(hs), 0);
    chk("R8", "restart vsync active", int'(vs), 0);
    chk("R8", "restart frame pulse", int'(fs), 1);
    chk("R8", "restart counters", int'(hc) + int'(vc), 0);
    @(negedge clk);
    chk("R8", "restart hcount steps", int'(hc), 1);
  endtask

  initial begin
    t_reset();
    t_frame_a();
    t_frame_b();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule